// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flags and Alarm Match

This block is the event and interrupt corner of a real-time clock. It watches two strobes from the timekeeping logic: one that marks the end of each once-per-second update and one that marks each edge of the periodic tap. On every update strobe it compares the current hours, minutes and seconds against three programmable alarm bytes. An alarm byte whose two top bits are both 1 matches any value.

Three event flags are kept in a status register. A flag is set whether or not its enable is on. A configuration register holds one enable per flag, and a summary bit is formed from any flag whose enable is also set. The active-low interrupt pin follows the summary bit. Reading the status register hands back its value and clears every flag. A flag whose strobe arrives in the same cycle as that read is kept, so no event is lost.

The host uses a three-bit register select with separate read and write enables. Read data is combinational from the selected register. A fixed register always returns the valid-RAM indication.

Top module: `rtc_irq_core`

## Requirements
- R1: Select 4 reads the status register: bit 4 is the update flag, bit 5 the alarm flag, bit 6 the periodic flag and bit 7 the summary bit. Bits 3:0 read 0. A write to select 4 changes nothing.
- R2: An update strobe sets bit 4 of the status register and a periodic strobe sets bit 6. This happens even when the matching enable is 0, and in that case the interrupt pin stays high.
- R3: The alarm flag (status bit 5) is set only with an update strobe. It requires the hours, minutes and seconds presented with that strobe to each equal their alarm byte, or that alarm byte to have bits 7:6 equal to 11. A match with no strobe sets nothing.
- R4: The summary bit is 1 when at least one flag is 1 together with its enable. The enables are bits 4, 5 and 6 of the configuration register (select 3). irq_n is the inverse of the summary bit and changes in the same cycle.
- R5: A read of select 4 with rd_en returns the current value in that cycle. From the next cycle every flag is 0.
- R6: A strobe that falls in the same cycle as a status read does not show in that read's data, but its flag is 1 afterwards.
- R7: On a configuration write, bits 4, 5 and 6 load the three enables and bit 7 loads the hold bit. A write with bit 7 set forces the update enable to 0. Bits 3:0 read 0.
- R8: Select 5 always reads 0x80, and writes to it are ignored.
- R9: A synchronous active-high reset clears the flags, the enables, the hold bit and the alarm bytes, and leaves irq_n high.
- R10: Selects 0, 1 and 2 hold the seconds, minutes and hours alarm bytes and read back the last value written.
- R11: Selects 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register select for read and write |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; on the status register it clears the flags |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data of the selected register |
| upd_strobe | input | 1 | One-cycle pulse after the time has advanced |
| per_strobe | input | 1 | One-cycle pulse on the periodic tap edge |
| cur_sec | input | 8 | Current seconds, valid with upd_strobe |
| cur_min | input | 8 | Current minutes, valid with upd_strobe |
| cur_hr | input | 8 | Current hours, valid with upd_strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A host read of the status register and a flag-setting strobe can land on the same clock edge. One of them clears the flag bank while the other sets a bit in it. The bench drives rd_en on the status select together with a periodic strobe in one cycle. It then judges the read data taken in that cycle against the old contents, and a second read against the new flag together with its summary bit. The same overlap between a clear and a set is also checked by a property on the flag bank.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int BYTE_W    = 8;
    localparam int SEL_W     = 3;
    localparam int NUM_ALARM = 3;
    localparam int EVT_LSB   = 4;
    localparam int NUM_EVT   = 3;
    localparam logic [BYTE_W-1:0] FIXED_VALUE = 8'h80;

    typedef enum logic [SEL_W-1:0] {
        SEL_ALM_SEC = 3'd0,
        SEL_ALM_MIN = 3'd1,
        SEL_ALM_HR  = 3'd2,
        SEL_CTRL    = 3'd3,
        SEL_STAT    = 3'd4,
        SEL_FIXED   = 3'd5
    } reg_sel_e;

    // Field order matches status and configuration bits 6..4.
    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } evt_vec_t;

    function automatic logic alarm_byte_hit(input logic [BYTE_W-1:0] alm,
                                            input logic [BYTE_W-1:0] now);
        return (alm[BYTE_W-1 -: 2] == 2'b11) || (alm == now);
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input evt_vec_t f, input logic sum);
        return {sum, f, {EVT_LSB{1'b0}}};
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ctrl(input evt_vec_t en, input logic hold);
        return {hold, en, {EVT_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_irq_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int NA = NUM_ALARM
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NA-1:0]    wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic [NA*DW-1:0] now_flat,
    output logic [NA*DW-1:0] alarm_flat,
    output logic             hit
);
    logic [NA-1:0] byte_hit;

    for (genvar i = 0; i < NA; i++) begin : g_byte
        logic [DW-1:0] alm_q;
        always_ff @(posedge clk) begin
            if (rst)            alm_q <= '0;
            else if (wr_sel[i]) alm_q <= wr_data;
        end
        assign alarm_flat[i*DW +: DW] = alm_q;
        assign byte_hit[i] = alarm_byte_hit(alm_q, now_flat[i*DW +: DW]);

        assert_alarm_load_R10: assert property (@(posedge clk) disable iff (rst)
            wr_sel[i] |=> (alm_q == $past(wr_data)));
    end

    assign hit = &byte_hit;

endmodule

// File: rtl/rtc_enable_reg.sv
module rtc_enable_reg
    import rtc_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  logic [3:0] wr_hi,   // bit 3 hold, bits 2:0 per/alm/upd enables
    output evt_vec_t en_o,
    output logic     hold_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_o   <= '0;
            hold_o <= 1'b0;
        end else if (wr_en) begin
            en_o.per <= wr_hi[2];
            en_o.alm <= wr_hi[1];
            en_o.upd <= wr_hi[0] & ~wr_hi[3];
            hold_o   <= wr_hi[3];
        end
    end

    assert_hold_kills_upd_en_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_hi[3]) |=> !en_o.upd);

    assert_reset_clears_en_R9: assert property (@(posedge clk)
        rst |=> (en_o == '0 && !hold_o));

endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank
    import rtc_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t set_i,
    input  logic     clr_i,
    input  evt_vec_t en_i,
    output evt_vec_t flags_o,
    output logic     sum_o
);
    logic [NUM_EVT-1:0] cur, nxt, setv, env;

    assign cur  = flags_o;
    assign setv = set_i;
    assign env  = en_i;
    assign nxt  = (clr_i ? '0 : cur) | setv;

    always_ff @(posedge clk) begin
        if (rst) flags_o <= '0;
        else     flags_o <= evt_vec_t'(nxt);
    end

    assign sum_o = |(cur & env);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && setv == '0) |=> (flags_o == '0));

    for (genvar k = 0; k < NUM_EVT; k++) begin : g_chk
        logic fk;
        assign fk = cur[k];
        assert_set_kept_R6: assert property (@(posedge clk) disable iff (rst)
            setv[k] |=> fk);
    end

    assert_reset_clears_flags_R9: assert property (@(posedge clk)
        rst |=> (flags_o == '0));

endmodule

// File: rtl/rtc_irq_core.sv
module rtc_irq_core
    import rtc_irq_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] reg_sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          upd_strobe,
    input  logic          per_strobe,
    input  logic [DW-1:0] cur_sec,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hr,
    output logic          irq_n
);
    localparam int NA = NUM_ALARM;

    logic [NA-1:0]    alm_wr_sel;
    logic [NA*DW-1:0] now_flat;
    logic [NA*DW-1:0] alarm_flat;
    logic             alarm_hit;
    logic             ctrl_wr;
    logic             stat_rd;
    evt_vec_t         en_w;
    logic             hold_w;
    evt_vec_t         set_w;
    evt_vec_t         flags_w;
    logic             sum_w;

    for (genvar i = 0; i < NA; i++) begin : g_alm_sel
        assign alm_wr_sel[i] = wr_en && (reg_sel == SW'(i));
    end

    assign now_flat = {cur_hr, cur_min, cur_sec};
    assign ctrl_wr  = wr_en && (reg_sel == SEL_CTRL);
    assign stat_rd  = rd_en && (reg_sel == SEL_STAT);

    rtc_alarm_match #(.DW(DW), .NA(NA)) u_alarm (
        .clk        (clk),
        .rst        (rst),
        .wr_sel     (alm_wr_sel),
        .wr_data    (wr_data),
        .now_flat   (now_flat),
        .alarm_flat (alarm_flat),
        .hit        (alarm_hit)
    );

    rtc_enable_reg u_enable (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ctrl_wr),
        .wr_hi  (wr_data[DW-1 -: 4]),
        .en_o   (en_w),
        .hold_o (hold_w)
    );

    always_comb begin
        set_w.upd = upd_strobe;
        set_w.alm = upd_strobe && alarm_hit;
        set_w.per = per_strobe;
    end

    rtc_flag_bank u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_w),
        .clr_i   (stat_rd),
        .en_i    (en_w),
        .flags_o (flags_w),
        .sum_o   (sum_w)
    );

    assign irq_n = ~sum_w;

    always_comb begin
        unique case (reg_sel)
            SEL_ALM_SEC: rd_data = alarm_flat[0*DW +: DW];
            SEL_ALM_MIN: rd_data = alarm_flat[1*DW +: DW];
            SEL_ALM_HR:  rd_data = alarm_flat[2*DW +: DW];
            SEL_CTRL:    rd_data = pack_ctrl(en_w, hold_w);
            SEL_STAT:    rd_data = pack_status(flags_w, sum_w);
            SEL_FIXED:   rd_data = FIXED_VALUE;
            default:     rd_data = '0;
        endcase
    end

    assert_alarm_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (upd_strobe && alarm_hit) |=> flags_w.alm);

    assert_alarm_needs_update_R3: assert property (@(posedge clk) disable iff (rst)
        (!upd_strobe && !flags_w.alm) |=> !flags_w.alm);

    assert_irq_pin_R4: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> ($countones({flags_w.per & en_w.per,
                                flags_w.alm & en_w.alm,
                                flags_w.upd & en_w.upd}) > 0));

    assert_fixed_reg_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == SEL_FIXED) |-> (rd_data == 8'h80));

endmodule

// File: tb/rtc_irq_core_bench.sv
`timescale 1ns/1ps
module rtc_irq_core_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_sel = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       upd_strobe = 1'b0;
    logic       per_strobe = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hr = '0;
    logic       irq_n;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rtc_irq_core u_rtc_irq_core (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .upd_strobe(upd_strobe),
        .per_strobe(per_strobe), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hr(cur_hr), .irq_n(irq_n)
    );

    // {expect_alarm, hr, min, sec, alarm_hr, alarm_min, alarm_sec}
    localparam logic [48:0] VEC [8] = '{
        {1'b1, 8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'h56},
        {1'b0, 8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'h57},
        {1'b1, 8'h23, 8'h00, 8'h00, 8'hC0, 8'h00, 8'h00},
        {1'b1, 8'h05, 8'h59, 8'h59, 8'hFF, 8'hC3, 8'hD9},
        {1'b0, 8'h00, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00},
        {1'b0, 8'h07, 8'h00, 8'h00, 8'h40, 8'h00, 8'h00},
        {1'b0, 8'h01, 8'h02, 8'h03, 8'h01, 8'hC0, 8'h04},
        {1'b0, 8'h09, 8'h10, 8'h11, 8'hC1, 8'h11, 8'h11}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_upd(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        @(negedge clk);
        cur_hr = h; cur_min = m; cur_sec = s; upd_strobe = 1'b1;
        @(negedge clk);
        upd_strobe = 1'b0;
    endtask

    task automatic pulse_per();
        @(negedge clk);
        per_strobe = 1'b1;
        @(negedge clk);
        per_strobe = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd(3'd4, v); check("R9 status after reset", v, 8'h00);
        rd(3'd3, v); check("R9 ctrl after reset", v, 8'h00);
        rd(3'd2, v); check("R9 alarm hr after reset", v, 8'h00);
        check("R9 irq_n after reset", {7'b0, irq_n}, 8'h01);

        // R8 fixed register
        wr(3'd5, 8'h3C); rd(3'd5, v); check("R8 fixed reg", v, 8'h80);
        // R11 unused selects
        rd(3'd6, v); check("R11 sel 6", v, 8'h00);
        rd(3'd7, v); check("R11 sel 7", v, 8'h00);

        // R3 / R2 vector table, all enables off
        for (int i = 0; i < 8; i++) begin
            wr(3'd0, VEC[i][7:0]);
            wr(3'd1, VEC[i][15:8]);
            wr(3'd2, VEC[i][23:16]);
            rd(3'd4, v);
            pulse_upd(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24]);
            rd(3'd4, v);
            check($sformatf("R3 alarm vector %0d", i), v, {2'b00, VEC[i][48], 5'b10000});
            check($sformatf("R2 irq_n high, enables off %0d", i), {7'b0, irq_n}, 8'h01);
        end

        // R10 alarm readback
        wr(3'd0, 8'h21); wr(3'd1, 8'h43); wr(3'd2, 8'h65);
        rd(3'd0, v); check("R10 alarm sec", v, 8'h21);
        rd(3'd1, v); check("R10 alarm min", v, 8'h43);
        rd(3'd2, v); check("R10 alarm hr", v, 8'h65);

        // R3 match held on time inputs but no update strobe
        rd(3'd4, v);
        @(negedge clk); cur_hr = 8'h65; cur_min = 8'h43; cur_sec = 8'h21;
        repeat (3) @(negedge clk);
        rd(3'd4, v); check("R3 no strobe no alarm", v, 8'h00);

        // R1 status write ignored
        pulse_per();
        wr(3'd4, 8'h00);
        rd(3'd4, v); check("R1 R2 periodic flag, write ignored", v, 8'h40);
        rd(3'd4, v); check("R5 cleared by read", v, 8'h00);

        // R4 enable then event
        wr(3'd3, 8'h40);
        pulse_per();
        #1 check("R4 irq_n low", {7'b0, irq_n}, 8'h00);
        rd(3'd4, v); check("R4 summary bit set", v, 8'hC0);
        #1 check("R5 irq_n released after read", {7'b0, irq_n}, 8'h01);

        // R6 strobe in same cycle as status read
        @(negedge clk);
        reg_sel = 3'd4; rd_en = 1'b1; per_strobe = 1'b1;
        #1 v = rd_data;
        check("R6 read returns old value", v, 8'h00);
        @(negedge clk);
        rd_en = 1'b0; per_strobe = 1'b0;
        rd(3'd4, v); check("R6 flag kept after read", v, 8'hC0);

        // R7 configuration
        wr(3'd3, 8'h7F); rd(3'd3, v); check("R7 enables, low nibble 0", v, 8'h70);
        wr(3'd3, 8'hF0); rd(3'd3, v); check("R7 hold clears update enable", v, 8'hE0);
        pulse_upd(8'h00, 8'h00, 8'h00);
        #1 check("R7 update flag no irq", {7'b0, irq_n}, 8'h01);

        // R9 reset mid-run
        wr(3'd3, 8'h70);
        pulse_per();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1 check("R9 irq_n after mid reset", {7'b0, irq_n}, 8'h01);
        rd(3'd4, v); check("R9 status after mid reset", v, 8'h00);
        rd(3'd3, v); check("R9 ctrl after mid reset", v, 8'h00);
        rd(3'd0, v); check("R9 alarm sec after mid reset", v, 8'h00);

        finish_run();
    end

endmodule